// File: doc/BRIEF.md
# Column Task Dispatcher with Completion Flags

This block coordinates a group of worker processors that share a column-by-column matrix factorization. Workers ask it for work over a per-worker request line. It answers each request with the next column number from a single counter, so every column goes to exactly one worker. Columns are handed out in rising order, starting at column 1. Because the fetch and the increment happen in one grant cycle, two workers can never receive the same column. Once every column up to the programmed order has been handed out, requests are no longer granted.

Each column has a completion flag. A worker raises it through the set port after it has finished both the update and the scaling passes on that column. Other workers poll the query port, which returns the flag and the worker that was granted the column. A worker that needs one particular earlier column can therefore stall on that column alone, without waiting for a global barrier. A global completion output rises once every column has been issued and flagged.

A host write loads the matrix order and a run mode, and restarts the dispatcher. Mode 0 holds all workers idle. Mode 2 restricts the run to worker 1, and mode 3 restricts it to worker 0. Any other nonzero mode lets every worker take part, which makes serial and parallel timing runs easy to compare.

Top module: `chol_disp`

## Requirements
- R1: After reset no grant is given, `gnt_col` is 0, `done` is low, every completion flag reads 0, and the mode is 0.
- R2: Grants carry columns 1, 2, 3, … in strictly increasing order, one column per grant, with no column skipped or repeated; `gnt_col` is 0 in a cycle without a grant.
- R3: A request seen at a clock edge is answered by a `gnt` pulse in the following cycle. At most one `gnt` bit is high in any cycle. A worker granted in one cycle is not granted in the next cycle.
- R4: When the number of columns issued equals the stored order, no further grant is given until the next host write.
- R5: While the mode is 0, no grant is given.
- R6: Mode 2 lets only worker 1 (`req[1]`) be granted. Mode 3 lets only worker 0 (`req[0]`) be granted. Any other nonzero mode lets all workers be granted.
- R7: When several eligible workers request together, exactly one is granted, chosen round-robin. The priority search starts at the index after the last grantee, and worker 0 is first after reset or a host write.
- R8: A pulse on `rdy_set` with a column from 1 up to the number already issued sets that column's flag, and the flag is visible on `qry_ready` in the next cycle. A column of 0, or one not yet issued, is ignored.
- R9: `qry_owner` returns the index of the worker that was granted the queried column.
- R10: `done` is high exactly when the order is nonzero, all columns up to the order have been issued, and all of their flags are set.
- R11: A host write (`cfg_we`) clears the issue counter, all flags and owner records, and restarts round-robin at worker 0. It stores the order clamped to `MAX_COLS`, and it gives no grant in its own cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Host write strobe: load order and mode, restart |
| cfg_order | input | COL_W | Matrix order (clamped to MAX_COLS) |
| cfg_mode | input | 4 | Run mode: 0 idle, 2 worker 1 only, 3 worker 0 only, other all |
| req | input | NW | Per-worker task request, held until granted |
| gnt | output | NW | One-cycle grant pulse, at most one bit high |
| gnt_col | output | COL_W | Column handed out with the grant (1-based), else 0 |
| rdy_set | input | 1 | Mark a column as finished |
| rdy_set_col | input | COL_W | Column to mark |
| qry_col | input | COL_W | Column to look up |
| qry_ready | output | 1 | Completion flag of the queried column |
| qry_owner | output | ID_W | Worker that was granted the queried column |
| done | output | 1 | All columns issued and flagged |

## Verification
The hardest state to reach is the end of the task stream, where the last columns meet contending requests, the back-to-back mask and a saturated counter. The vector table drives both workers through a five-column run that mixes joint and single requests. This leaves one worker masked for a cycle and then lets it take the final column, after which every request is refused. The clamp case writes an order above the column capacity and keeps both workers requesting until the capacity is used up. Flag sets aimed at columns not yet issued are sent right after a restart, when the counter still sits below them.

// File: rtl/chol_disp_pkg.sv
package chol_disp_pkg;

    localparam int MODE_W = 4;

    // Run-mode classes derived from the host mode value
    typedef enum logic [1:0] {
        MC_HALT    = 2'd0,
        MC_ALL     = 2'd1,
        MC_ONLY_HI = 2'd2,   // worker index 1 alone
        MC_ONLY_LO = 2'd3    // worker index 0 alone
    } mode_cls_e;

    function automatic mode_cls_e classify_mode(input logic [MODE_W-1:0] m);
        mode_cls_e c;
        case (m)
            MODE_W'(0): c = MC_HALT;
            MODE_W'(2): c = MC_ONLY_HI;
            MODE_W'(3): c = MC_ONLY_LO;
            default:    c = MC_ALL;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/chol_disp_arb.sv
module chol_disp_arb #(
    parameter  int NW   = 2,
    localparam int ID_W = (NW > 1) ? $clog2(NW) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic [NW-1:0]   elig,
    output logic [NW-1:0]   pick,
    output logic [ID_W-1:0] pick_idx,
    output logic            pick_any
);

    typedef struct packed {
        logic [ID_W-1:0] last;
    } arb_st_t;

    localparam logic [ID_W-1:0] LAST_INIT = ID_W'(NW - 1);

    arb_st_t st_d, st_q;

    always_comb begin
        int cand;
        st_d     = st_q;
        pick     = '0;
        pick_idx = '0;
        pick_any = 1'b0;
        cand     = 0;
        // search starts one past the previous grantee
        for (int k = 0; k < NW; k++) begin
            cand = (int'(st_q.last) + 1 + k) % NW;
            if (!pick_any && elig[cand]) begin
                pick_any   = 1'b1;
                pick[cand] = 1'b1;
                pick_idx   = ID_W'(cand);
            end
        end
        if (pick_any) begin
            st_d.last = pick_idx;
        end
        if (clr) begin
            st_d.last = LAST_INIT;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.last <= LAST_INIT;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/chol_disp_tbl.sv
module chol_disp_tbl #(
    parameter  int NW       = 2,
    parameter  int MAX_COLS = 16,
    localparam int COL_W    = $clog2(MAX_COLS + 1),
    localparam int ID_W     = (NW > 1) ? $clog2(NW) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             own_we,
    input  logic [COL_W-1:0] own_col,
    input  logic [ID_W-1:0]  own_id,
    input  logic             set_en,
    input  logic [COL_W-1:0] set_col,
    input  logic [COL_W-1:0] issued,
    input  logic [COL_W-1:0] ord,
    input  logic [COL_W-1:0] qry_col,
    output logic             qry_ready,
    output logic [ID_W-1:0]  qry_owner,
    output logic             all_ready
);

    typedef struct packed {
        logic [MAX_COLS-1:0]           flag;
        logic [MAX_COLS-1:0][ID_W-1:0] own;
    } tbl_st_t;

    tbl_st_t st_d, st_q;

    logic set_ok;

    // a flag may only be raised on a column already handed out
    assign set_ok = set_en && (set_col != '0) && (set_col <= issued);

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < MAX_COLS; i++) begin
            if (own_we && (own_col == COL_W'(i + 1))) begin
                st_d.own[i] = own_id;
            end
            if (set_ok && (set_col == COL_W'(i + 1))) begin
                st_d.flag[i] = 1'b1;
            end
        end
        if (clr) begin
            st_d.flag = '0;
            st_d.own  = '0;
        end
    end

    always_comb begin
        qry_ready = 1'b0;
        qry_owner = '0;
        for (int i = 0; i < MAX_COLS; i++) begin
            if (qry_col == COL_W'(i + 1)) begin
                qry_ready = st_q.flag[i];
                qry_owner = st_q.own[i];
            end
        end
    end

    always_comb begin
        all_ready = 1'b1;
        for (int i = 0; i < MAX_COLS; i++) begin
            if ((COL_W'(i) < ord) && !st_q.flag[i]) begin
                all_ready = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.flag <= '0;
            st_q.own  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/chol_disp.sv
module chol_disp
    import chol_disp_pkg::*;
#(
    parameter  int NW       = 2,
    parameter  int MAX_COLS = 16,
    localparam int COL_W    = $clog2(MAX_COLS + 1),
    localparam int ID_W     = (NW > 1) ? $clog2(NW) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [COL_W-1:0]  cfg_order,
    input  logic [MODE_W-1:0] cfg_mode,
    input  logic [NW-1:0]     req,
    output logic [NW-1:0]     gnt,
    output logic [COL_W-1:0]  gnt_col,
    input  logic              rdy_set,
    input  logic [COL_W-1:0]  rdy_set_col,
    input  logic [COL_W-1:0]  qry_col,
    output logic              qry_ready,
    output logic [ID_W-1:0]   qry_owner,
    output logic              done
);

    localparam logic [COL_W-1:0] COL_CAP = COL_W'(MAX_COLS);
    localparam logic [NW-1:0]    ONLY_LO = NW'(1);
    localparam logic [NW-1:0]    ONLY_HI = (NW > 1) ? NW'(2) : '0;

    typedef struct packed {
        logic [COL_W-1:0]  cnt;
        logic [COL_W-1:0]  ord;
        logic [MODE_W-1:0] mode;
        logic [NW-1:0]     gnt;
        logic [COL_W-1:0]  col;
    } disp_st_t;

    disp_st_t  st_d, st_q;
    mode_cls_e mcls;
    logic [NW-1:0]   allow;
    logic [NW-1:0]   elig;
    logic            more;
    logic [NW-1:0]   pick;
    logic [ID_W-1:0] pick_idx;
    logic            pick_any;
    logic [COL_W-1:0] next_col;
    logic            all_ready;

    assign mcls     = classify_mode(st_q.mode);
    assign more     = (st_q.cnt != st_q.ord);
    assign next_col = st_q.cnt + 1'b1;

    always_comb begin
        case (mcls)
            MC_HALT:    allow = '0;
            MC_ONLY_HI: allow = ONLY_HI;
            MC_ONLY_LO: allow = ONLY_LO;
            default:    allow = '1;
        endcase
    end

    // last cycle's grantee sits out one cycle so a held request is not re-served
    assign elig = req & ~st_q.gnt & allow & {NW{more && !cfg_we}};

    chol_disp_arb #(.NW(NW)) u_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (cfg_we),
        .elig     (elig),
        .pick     (pick),
        .pick_idx (pick_idx),
        .pick_any (pick_any)
    );

    always_comb begin
        st_d     = st_q;
        st_d.gnt = pick;
        st_d.col = pick_any ? next_col : '0;
        if (pick_any) begin
            st_d.cnt = next_col;
        end
        if (cfg_we) begin
            st_d.ord  = (cfg_order > COL_CAP) ? COL_CAP : cfg_order;
            st_d.mode = cfg_mode;
            st_d.cnt  = '0;
            st_d.gnt  = '0;
            st_d.col  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt  <= '0;
            st_q.ord  <= '0;
            st_q.mode <= '0;
            st_q.gnt  <= '0;
            st_q.col  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    chol_disp_tbl #(.NW(NW), .MAX_COLS(MAX_COLS)) u_tbl (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (cfg_we),
        .own_we    (pick_any),
        .own_col   (next_col),
        .own_id    (pick_idx),
        .set_en    (rdy_set),
        .set_col   (rdy_set_col),
        .issued    (st_q.cnt),
        .ord       (st_q.ord),
        .qry_col   (qry_col),
        .qry_ready (qry_ready),
        .qry_owner (qry_owner),
        .all_ready (all_ready)
    );

    assign gnt     = st_q.gnt;
    assign gnt_col = st_q.col;
    assign done    = (st_q.ord != '0) && !more && all_ready;

endmodule

// File: rtl/chol_disp_chk.sv
module chol_disp_chk
    import chol_disp_pkg::*;
#(
    parameter  int NW       = 2,
    parameter  int MAX_COLS = 16,
    localparam int COL_W    = $clog2(MAX_COLS + 1),
    localparam int ID_W     = (NW > 1) ? $clog2(NW) : 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic [COL_W-1:0]  cfg_order,
    input logic [MODE_W-1:0] cfg_mode,
    input logic [NW-1:0]     req,
    input logic [NW-1:0]     gnt,
    input logic [COL_W-1:0]  gnt_col,
    input logic              rdy_set,
    input logic [COL_W-1:0]  rdy_set_col,
    input logic [COL_W-1:0]  qry_col,
    input logic              qry_ready,
    input logic [ID_W-1:0]   qry_owner,
    input logic              done
);

    logic [COL_W-1:0]  ord_sh;
    logic [MODE_W-1:0] mode_sh;
    logic [COL_W-1:0]  issued_sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ord_sh    <= '0;
            mode_sh   <= '0;
            issued_sh <= '0;
        end else if (cfg_we) begin
            ord_sh    <= (cfg_order > COL_W'(MAX_COLS)) ? COL_W'(MAX_COLS) : cfg_order;
            mode_sh   <= cfg_mode;
            issued_sh <= '0;
        end else if (|gnt) begin
            issued_sh <= issued_sh + 1'b1;
        end
    end

    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt)); // R3

    AST_GNT_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (|gnt) |-> ((gnt & ~$past(req)) == '0)); // R3

    AST_NO_REPEAT_GNT: assert property (@(posedge clk) disable iff (!rst_n)
        (|gnt) |-> ((gnt & $past(gnt)) == '0)); // R3

    AST_COL_SEQUENCE: assert property (@(posedge clk) disable iff (!rst_n)
        (|gnt) |-> (gnt_col == issued_sh + 1'b1)); // R2

    AST_ORDER_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (|gnt) |-> (issued_sh < ord_sh)); // R4

    AST_HALT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode_sh) == '0) |-> (gnt == '0)); // R5

    AST_DONE_ALL_ISSUED: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((issued_sh == ord_sh) && (ord_sh != '0))); // R10

endmodule

bind chol_disp chol_disp_chk #(.NW(NW), .MAX_COLS(MAX_COLS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_we      (cfg_we),
    .cfg_order   (cfg_order),
    .cfg_mode    (cfg_mode),
    .req         (req),
    .gnt         (gnt),
    .gnt_col     (gnt_col),
    .rdy_set     (rdy_set),
    .rdy_set_col (rdy_set_col),
    .qry_col     (qry_col),
    .qry_ready   (qry_ready),
    .qry_owner   (qry_owner),
    .done        (done)
);

// File: tb/chol_disp_bench.sv
module chol_disp_bench;

    localparam int NW       = 2;
    localparam int MAX_COLS = 16;
    localparam int COL_W    = $clog2(MAX_COLS + 1);
    localparam int ID_W     = 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_we = 1'b0;
    logic [COL_W-1:0] cfg_order = '0;
    logic [3:0]       cfg_mode = '0;
    logic [NW-1:0]    req = '0;
    logic [NW-1:0]    gnt;
    logic [COL_W-1:0] gnt_col;
    logic             rdy_set = 1'b0;
    logic [COL_W-1:0] rdy_set_col = '0;
    logic [COL_W-1:0] qry_col = '0;
    logic             qry_ready;
    logic [ID_W-1:0]  qry_owner;
    logic             done;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    chol_disp #(.NW(NW), .MAX_COLS(MAX_COLS)) u_chol_disp (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_order(cfg_order),
        .cfg_mode(cfg_mode), .req(req), .gnt(gnt), .gnt_col(gnt_col),
        .rdy_set(rdy_set), .rdy_set_col(rdy_set_col), .qry_col(qry_col),
        .qry_ready(qry_ready), .qry_owner(qry_owner), .done(done)
    );

    // {req[1:0], expected gnt[1:0], expected gnt_col[4:0]}, order 5, all-workers mode
    localparam int NV = 8;
    localparam logic [8:0] VEC [NV] = '{
        {2'b11, 2'b01, 5'd1},
        {2'b11, 2'b10, 5'd2},
        {2'b11, 2'b01, 5'd3},
        {2'b10, 2'b10, 5'd4},
        {2'b10, 2'b00, 5'd0},
        {2'b10, 2'b10, 5'd5},
        {2'b11, 2'b00, 5'd0},
        {2'b01, 2'b00, 5'd0}
    };

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic host_write(input int ord, input int mode);
        req       = '0;
        cfg_we    = 1'b1;
        cfg_order = COL_W'(ord);
        cfg_mode  = 4'(mode);
        tick();
        cfg_we    = 1'b0;
    endtask

    task automatic mark(input int col);
        rdy_set     = 1'b1;
        rdy_set_col = COL_W'(col);
        tick();
        rdy_set     = 1'b0;
    endtask

    task automatic look(input int col, input int exp_rdy, input string tag);
        qry_col = COL_W'(col);
        #1;
        check(qry_ready == exp_rdy[0], tag, int'(qry_ready), exp_rdy);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int grants;
        int last_col;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        tick();

        // R1 reset state
        check(gnt == '0, "R1 gnt after reset", int'(gnt), 0);
        check(gnt_col == '0, "R1 gnt_col after reset", int'(gnt_col), 0);
        check(done == 1'b0, "R1 done after reset", int'(done), 0);
        look(1, 0, "R1 flag clear after reset");

        // R5 mode 0 after reset: requests wait
        req = 2'b11;
        for (int i = 0; i < 3; i++) begin
            tick();
            check(gnt == '0, "R5 no grant in mode 0", int'(gnt), 0);
        end

        // R2 R3 R4 R6 R7 table walk
        host_write(5, 1);
        for (int v = 0; v < NV; v++) begin
            req = VEC[v][8:7];
            tick();
            check(gnt == VEC[v][6:5], "R7 R3 grant vector", int'(gnt), int'(VEC[v][6:5]));
            check(gnt_col == VEC[v][4:0], "R2 R4 granted column", int'(gnt_col), int'(VEC[v][4:0]));
        end
        req = '0;

        // R9 owners: col1 w0, col2 w1, col3 w0, col4 w1, col5 w1
        qry_col = 5'd1; #1; check(qry_owner == 1'b0, "R9 owner col1", int'(qry_owner), 0);
        qry_col = 5'd2; #1; check(qry_owner == 1'b1, "R9 owner col2", int'(qry_owner), 1);
        qry_col = 5'd3; #1; check(qry_owner == 1'b0, "R9 owner col3", int'(qry_owner), 0);
        qry_col = 5'd5; #1; check(qry_owner == 1'b1, "R9 owner col5", int'(qry_owner), 1);

        // R8 ignored sets: col 0 and col 6 (never issued)
        mark(0);
        mark(6);
        look(6, 0, "R8 unissued column stays clear");
        check(done == 1'b0, "R8 ignored set leaves done low", int'(done), 0);

        // R8 R10 flags then done
        for (int c = 1; c <= 4; c++) begin
            mark(c);
        end
        look(4, 1, "R8 flag set next cycle");
        check(done == 1'b0, "R10 done low with one flag missing", int'(done), 0);
        mark(5);
        check(done == 1'b1, "R10 done with all flags", int'(done), 1);

        // R11 restart clears, R6 mode 2 only worker 1
        host_write(3, 2);
        look(1, 0, "R11 flag cleared by host write");
        check(done == 1'b0, "R11 done cleared", int'(done), 0);
        req = 2'b11;
        tick();
        check(gnt == 2'b10, "R6 mode 2 grants worker 1", int'(gnt), 2);
        check(gnt_col == 5'd1, "R11 counter restarted", int'(gnt_col), 1);
        req = 2'b01;
        for (int i = 0; i < 3; i++) begin
            tick();
            check(gnt == '0, "R6 mode 2 blocks worker 0", int'(gnt), 0);
        end

        // R6 mode 3 only worker 0; R8 set before issue ignored
        host_write(3, 3);
        mark(2);
        look(2, 0, "R8 set before issue ignored");
        req = 2'b11;
        tick();
        check(gnt == 2'b01, "R6 mode 3 grants worker 0", int'(gnt), 1);
        req = 2'b10;
        tick();
        tick();
        check(gnt == '0, "R6 mode 3 blocks worker 1", int'(gnt), 0);

        // R11 clamp: order 20 -> 16 columns
        host_write(20, 5);
        req = 2'b11;
        grants = 0;
        last_col = 0;
        for (int i = 0; i < 40; i++) begin
            tick();
            if (gnt != '0) begin
                grants++;
                last_col = int'(gnt_col);
            end
        end
        req = '0;
        check(grants == MAX_COLS, "R11 clamped grant count", grants, MAX_COLS);
        check(last_col == MAX_COLS, "R11 last clamped column", last_col, MAX_COLS);

        // R10 order 0 never done
        host_write(0, 1);
        tick();
        check(done == 1'b0, "R10 order zero not done", int'(done), 0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule